// File: doc/BRIEF.md
# Boot Sector Write Protection Unit

This unit sits beside the command engine of a 512K x 16 flash array. It decides which word addresses may be written or erased. Each request carries an operation code, a word address and an override flag. The override flag stands for the high-voltage reset condition, and an analog detector outside this block produces it. The unit answers one clock later with a grant or a reject pulse and a four-bit mask of the regions the operation touches. The array is split into a boot block, two parameter blocks and a main array. Storage, voltage sensing and erase timing belong to other blocks.

The boot block can sit at the bottom or the top of the address space. A parameter selects the placement, and the parameter blocks follow the boot block in the same direction. A sticky lockout flag is set by its own command. Until it is set, the boot block and the main array behave as one erase sector. Once it is set, the boot block leaves every erase and every program, unless the override flag accompanies the request. The lockout state can be read on bit 0 of the identification read at word address 2.

The unit has two reset inputs. The power-on reset clears everything, including the lockout flag. The functional reset clears only the response pulses and the mask. Both resets assert asynchronously and release through a two-stage synchronizer.

Top module: `boot_guard`

## Requirements
- R1: With bottom placement, address block index `addr >> BLK_W` selects the region as follows: 0 is boot, 1 is parameter 1, 2 is parameter 2, and any higher index is main.
- R2: With top placement, the same mapping applies to the bitwise inverse of the block index, so the highest block is boot, the next lower is parameter 1, the one below that is parameter 2, and the rest is main.
- R3: The mask encodes regions as bit0 parameter 1, bit1 parameter 2, bit2 main and bit3 boot. It is registered and valid in the cycle after the request. A program or sector erase aimed at a parameter block grants exactly that block.
- R4: With lockout clear, a sector erase at a main or boot address grants mask 1100 (main and boot together).
- R5: With lockout set and no override, a sector erase at a main or boot address grants mask 0100 (main only).
- R6: A chip erase is always granted: the mask is 1111 with lockout clear or override present, and 0111 with lockout set and no override.
- R7: A word program is granted with the mask of its own region, except at a boot address with lockout set and no override. That case raises a one-cycle reject with mask 0000.
- R8: An override present with the request makes the lockout flag have no effect on that request.
- R9: Operation codes are 00 program, 01 sector erase, 10 chip erase and 11 lockout set. A lockout-set request is granted with mask 0000 and sets the flag from the next cycle.
- R10: The identification bit equals the lockout flag when the identification address is 2, and is 0 at any other address.
- R11: The lockout flag survives the functional reset, and only the power-on reset clears it.
- R12: The functional reset clears grant, reject and the mask. Each accepted request gives exactly one of grant or reject, and a cycle without a request gives neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears the lockout flag |
| rst_n | input | 1 | Functional reset, active low, keeps the lockout flag |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_op | input | 2 | Operation code: 00 program, 01 sector erase, 10 chip erase, 11 lockout set |
| req_addr | input | ADDR_W | Word address of the program, or sector address of the erase |
| req_override | input | 1 | High-voltage override present for this request |
| id_addr | input | ADDR_W | Address of the identification read |
| grant | output | 1 | One-cycle pulse: request permitted |
| reject | output | 1 | One-cycle pulse: request refused, nothing started |
| region_mask | output | 4 | Regions affected by the granted request |
| id_lock_bit | output | 1 | Bit 0 of the identification read data |

## Verification
The assertions assume that a request is applied only once the released resets have passed through the synchronizers, and that the operation code and override stay stable at the edge that samples the strobe. To meet this, the bench waits several idle cycles after each reset release. It drives every input on the falling edge and holds the strobe for exactly one cycle. Every address of a small bottom configuration and a small top configuration is swept with each operation, each override value and both lockout states. The expected mask for each point is computed from the block index.

// File: rtl/bgp_pkg.sv
package bgp_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2,
    OP_LOCK = 2'd3
  } bg_op_e;

  localparam int RG_P1   = 0;
  localparam int RG_P2   = 1;
  localparam int RG_MAIN = 2;
  localparam int RG_BOOT = 3;
  localparam int RG_N    = 4;
endpackage

// File: rtl/bgp_rst_sync.sv
module bgp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/bgp_region_decode.sv
module bgp_region_decode
  import bgp_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int BLK_W    = 13,
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [RG_N-1:0]   region
);
  localparam int IDX_W = ADDR_W - BLK_W;

  logic [IDX_W-1:0] idx;

  generate
    if (TOP_BOOT) begin : g_top
      assign idx = ~addr[ADDR_W-1:BLK_W];
    end else begin : g_bottom
      assign idx = addr[ADDR_W-1:BLK_W];
    end
  endgenerate

  always_comb begin
    region = '0;
    if (idx == IDX_W'(0))      region[RG_BOOT] = 1'b1;
    else if (idx == IDX_W'(1)) region[RG_P1]   = 1'b1;
    else if (idx == IDX_W'(2)) region[RG_P2]   = 1'b1;
    else                       region[RG_MAIN] = 1'b1;
  end
endmodule

// File: rtl/bgp_policy.sv
module bgp_policy
  import bgp_pkg::*;
(
  input  bg_op_e          op,
  input  logic [RG_N-1:0] region,
  input  logic            locked,
  input  logic            override_hv,
  output logic            permit,
  output logic            set_lock,
  output logic [RG_N-1:0] mask
);
  logic guard;
  logic boot_sector;

  assign guard       = locked & ~override_hv;
  assign boot_sector = region[RG_MAIN] | region[RG_BOOT];

  always_comb begin
    permit   = 1'b1;
    set_lock = 1'b0;
    mask     = '0;
    unique case (op)
      OP_PROG: begin
        if (region[RG_BOOT] && guard) permit = 1'b0;
        else                          mask   = region;
      end
      OP_SECT: begin
        if (boot_sector) begin
          mask[RG_MAIN] = 1'b1;
          mask[RG_BOOT] = ~guard;
        end else begin
          mask = region;
        end
      end
      OP_CHIP: begin
        mask[RG_P1]   = 1'b1;
        mask[RG_P2]   = 1'b1;
        mask[RG_MAIN] = 1'b1;
        mask[RG_BOOT] = ~guard;
      end
      OP_LOCK: set_lock = 1'b1;
      default: permit = 1'b0;
    endcase
  end
endmodule

// File: rtl/boot_guard.sv
module boot_guard
  import bgp_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int BLK_W    = 13,
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_override,
  input  logic [ADDR_W-1:0] id_addr,
  output logic              grant,
  output logic              reject,
  output logic [3:0]        region_mask,
  output logic              id_lock_bit
);
  localparam logic [ADDR_W-1:0] ID_LOCK_ADDR = ADDR_W'(2);

  logic            por_sync_n;
  logic            run;
  logic [RG_N-1:0] region;
  logic            permit;
  logic            set_lock;
  logic [RG_N-1:0] pol_mask;

  logic            lock_q,  lock_d;
  logic            grant_q, grant_d;
  logic            rej_q,   rej_d;
  logic [RG_N-1:0] mask_q,  mask_d;

  bgp_rst_sync u_por_sync (
    .clk    (clk),
    .arst_n (por_n),
    .srst_n (por_sync_n)
  );

  bgp_rst_sync u_fn_sync (
    .clk    (clk),
    .arst_n (rst_n & por_n),
    .srst_n (run)
  );

  bgp_region_decode #(
    .ADDR_W   (ADDR_W),
    .BLK_W    (BLK_W),
    .TOP_BOOT (TOP_BOOT)
  ) u_dec (
    .addr   (req_addr),
    .region (region)
  );

  bgp_policy u_pol (
    .op          (bg_op_e'(req_op)),
    .region      (region),
    .locked      (lock_q),
    .override_hv (req_override),
    .permit      (permit),
    .set_lock    (set_lock),
    .mask        (pol_mask)
  );

  always_comb begin
    lock_d  = lock_q;
    grant_d = 1'b0;
    rej_d   = 1'b0;
    mask_d  = '0;
    if (req_valid) begin
      grant_d = permit;
      rej_d   = ~permit;
      mask_d  = pol_mask;
      if (set_lock) lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_sync_n) begin
    if (!por_sync_n)  lock_q <= 1'b0;
    else if (run)     lock_q <= lock_d;
  end

  always_ff @(posedge clk or negedge run) begin
    if (!run) begin
      grant_q <= 1'b0;
      rej_q   <= 1'b0;
      mask_q  <= '0;
    end else begin
      grant_q <= grant_d;
      rej_q   <= rej_d;
      mask_q  <= mask_d;
    end
  end

  assign grant       = grant_q;
  assign reject      = rej_q;
  assign region_mask = mask_q;
  assign id_lock_bit = lock_q & (id_addr == ID_LOCK_ADDR);
endmodule

// File: rtl/bgp_checker.sv
module bgp_checker (
  input logic       clk,
  input logic       por_n,
  input logic       rst_n,
  input logic       run,
  input logic       req_valid,
  input logic [1:0] req_op,
  input logic       req_override,
  input logic [3:0] region,
  input logic       lock,
  input logic       grant,
  input logic       reject,
  input logic [3:0] region_mask
);
  p_one_outcome_r12: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (run && req_valid) |=> (grant ^ reject));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (run && !req_valid) |=> (!grant && !reject));

  p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    !(grant && reject));

  p_reject_empty_r7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    reject |-> (region_mask == 4'b0000));

  p_prog_boot_refused_r7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (run && req_valid && req_op == 2'd0 && region[3] && lock && !req_override) |=> reject);

  p_boot_guarded_r5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (run && req_valid && lock && !req_override) |=> !region_mask[3]);

  p_chip_all_r6: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (run && req_valid && req_op == 2'd2) |=> (grant && region_mask[2:0] == 3'b111));

  p_sticky_r11: assert property (@(posedge clk) disable iff (!por_n)
    lock |=> lock);
endmodule

bind boot_guard bgp_checker u_chk (
  .clk          (clk),
  .por_n        (por_n),
  .rst_n        (rst_n),
  .run          (run),
  .req_valid    (req_valid),
  .req_op       (req_op),
  .req_override (req_override),
  .region       (region),
  .lock         (lock_q),
  .grant        (grant),
  .reject       (reject),
  .region_mask  (region_mask)
);

// File: tb/sim_boot_guard.sv
module sim_boot_guard;
  localparam int AW = 7;
  localparam int BW = 3;
  localparam int NB = 1 << (AW - BW);

  logic          clk = 1'b0;
  logic          por_n, rst_n, req_valid, req_override;
  logic [1:0]    req_op;
  logic [AW-1:0] req_addr, id_addr;
  logic          g0, r0, i0, g1, r1, i1;
  logic [3:0]    m0, m1;
  int            n_chk = 0;
  int            n_fail = 0;

  always #10 clk = ~clk;

  boot_guard #(.ADDR_W(AW), .BLK_W(BW), .TOP_BOOT(1'b0)) u0 (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .req_valid(req_valid),
    .req_op(req_op), .req_addr(req_addr), .req_override(req_override),
    .id_addr(id_addr), .grant(g0), .reject(r0), .region_mask(m0),
    .id_lock_bit(i0));

  boot_guard #(.ADDR_W(AW), .BLK_W(BW), .TOP_BOOT(1'b1)) u1 (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .req_valid(req_valid),
    .req_op(req_op), .req_addr(req_addr), .req_override(req_override),
    .id_addr(id_addr), .grant(g1), .reject(r1), .region_mask(m1),
    .id_lock_bit(i1));

  task automatic chk(string tag, logic [5:0] act, logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // region: 0 boot, 1 p1, 2 p2, 3 main (R1, R2)
  function automatic int region_of(int a, bit top);
    int idx = a >> BW;
    if (top) idx = NB - 1 - idx;
    if (idx == 0) return 0;
    if (idx == 1) return 1;
    if (idx == 2) return 2;
    return 3;
  endfunction

  // expected {grant, reject, mask}, mask bit0 p1, bit1 p2, bit2 main, bit3 boot
  function automatic logic [5:0] expect_out(int op, int a, bit top, bit lk, bit ov);
    int  rg = region_of(a, top);
    bit  gd = lk && !ov;
    logic [3:0] own;
    own = (rg == 0) ? 4'b1000 : (rg == 1) ? 4'b0001 : (rg == 2) ? 4'b0010 : 4'b0100;
    case (op)
      0: return (rg == 0 && gd) ? 6'b01_0000 : {2'b10, own};
      1: return (rg == 1 || rg == 2) ? {2'b10, own} : {2'b10, !gd, 3'b100};
      2: return {2'b10, !gd, 3'b111};
      default: return 6'b10_0000;
    endcase
  endfunction

  task automatic issue(int op, int a, bit ov);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_addr = AW'(a); req_override = ov;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic sweep(bit lk);
    for (int op = 0; op < 3; op++)
      for (int ov = 0; ov < 2; ov++)
        for (int a = 0; a < (1 << AW); a++) begin
          issue(op, a, bit'(ov));
          chk($sformatf("R1 R3 R4 R5 R6 R7 R8 bottom op=%0d a=%0d ov=%0d lk=%0d", op, a, ov, lk),
              {g0, r0, m0}, expect_out(op, a, 1'b0, lk, bit'(ov)));
          chk($sformatf("R2 R3 R4 R5 R6 R7 R8 top op=%0d a=%0d ov=%0d lk=%0d", op, a, ov, lk),
              {g1, r1, m1}, expect_out(op, a, 1'b1, lk, bit'(ov)));
        end
  endtask

  task automatic id_check(string tag, int a, bit exp);
    @(negedge clk);
    id_addr = AW'(a);
    #1;
    chk(tag, {4'b0, i0, i1}, {4'b0, exp, exp});
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    por_n = 1'b0; rst_n = 1'b0; req_valid = 1'b0; req_op = 2'd0;
    req_addr = '0; req_override = 1'b0; id_addr = AW'(2);
    repeat (3) @(negedge clk);
    chk("R12 reset state", {g0, r0, m0}, 6'b0);
    chk("R12 reset state top", {g1, r1, m1}, 6'b0);
    por_n = 1'b1; rst_n = 1'b1;
    repeat (4) @(negedge clk);
    id_check("R10 unlocked id bit", 2, 1'b0);

    sweep(1'b0);

    issue(3, 0, 1'b0);
    chk("R9 lock set bottom", {g0, r0, m0}, 6'b10_0000);
    chk("R9 lock set top", {g1, r1, m1}, 6'b10_0000);
    id_check("R10 locked id bit at 2", 2, 1'b1);
    id_check("R10 id bit at 3", 3, 1'b0);
    id_check("R10 id bit at 0", 0, 1'b0);

    sweep(1'b1);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R12 functional reset clears outputs", {g0, r0, m0}, 6'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    id_check("R11 lock survives functional reset", 2, 1'b1);
    issue(1, 0, 1'b0);
    chk("R11 R5 lock still guards boot", {g0, r0, m0}, 6'b10_0100);
    @(negedge clk);
    chk("R12 idle cycle quiet", {g0, r0, m0}, 6'b0);

    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    repeat (4) @(negedge clk);
    id_check("R11 power-on reset clears lock", 2, 1'b0);
    issue(2, 5, 1'b0);
    chk("R11 R6 chip erase after power-on reset", {g1, r1, m1}, 6'b10_1111);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule